// File: doc/BRIEF.md
# Accumulator ALU with Status Flag Register

This block pairs an 8-bit accumulator with an arithmetic and logic stage and an 8-bit status word. Each cycle in which an operation is issued, the stage combines the accumulator with a second operand. The result is written back into the accumulator on the next clock edge. Arithmetic operations also refresh the carry, half-carry and signed overflow flags in the status word.

The carry flag held in the status word is the carry-in for add-with-carry and for subtract-with-borrow. The status word also holds a general-purpose user flag and two register-bank select bits. Software-style commands can write the status word as a whole byte or one bit at a time, and can force the carry flag high or low. The parity bit is not stored. It is always derived from the current accumulator contents.

All state is registered, with a synchronous active-high reset. The accumulator and the status word can be read directly at the outputs.

Top module: `alu_psw_unit`

## Requirements
- R1: With `op_valid` high and `op_sel`=0 (add), the accumulator becomes (acc + B) mod 256. Status bit 7 (carry) is set to the carry out of bit 7. Bit 6 (half-carry) is set to the carry out of bit 3. Bit 2 (overflow) is set to the XOR of the carry into bit 7 and the carry out of bit 7. The stored carry is not used as an input.
- R2: With `op_sel`=1 (add with carry), the operation is the same as R1, but the stored status bit 7 is added as the carry-in.
- R3: With `op_sel`=2 (subtract with borrow), the accumulator becomes (acc − B − CY) mod 256. Bit 7 is 1 exactly when acc < B + CY (unsigned). Bit 6 is 1 exactly when the low nibble of acc is less than the low nibble of B plus CY. Bit 2 is 1 exactly when the signed difference lies outside −128..127.
- R4: `op_sel` 3, 4, 5, 6 and 7 load the accumulator with, in turn: acc AND B, acc OR B, acc XOR B, NOT acc (B is ignored), and B itself. None of these changes status bits 7..2.
- R5: Status bit 0 is 1 when the accumulator holds an odd number of ones and 0 otherwise. It follows the accumulator in the same cycle that the accumulator changes. A value written to bit 0 is ignored.
- R6: `cy_set` forces bit 7 to 1 and `cy_clr` forces it to 0; when both are high, set wins. No other bit changes.
- R7: A byte write (`psw_we`) stores `psw_wd` bits 7..2: carry at 7, half-carry at 6, user flag at 5, bank select high at 4, bank select low at 3, overflow at 2. Bit 1 always reads 0.
- R8: A bit write (`bit_we`) with `bit_idx` 2..7 sets that one bit to `bit_d` and leaves the others unchanged. Index 0 or 1 has no effect.
- R9: Reset clears the accumulator to 00h and the status word to 00h.
- R10: Results appear on the outputs one clock after the command. In the status word, a byte write overrides a bit write. A bit write overrides set/clear carry. Set/clear carry overrides the flags produced by arithmetic. The accumulator is still updated by an operation issued in the same cycle. With `op_valid` low, the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Issue an operation this cycle |
| op_sel | input | 3 | Operation code (0 add, 1 add with carry, 2 subtract with borrow, 3 AND, 4 OR, 5 XOR, 6 complement, 7 move B) |
| opnd_b | input | 8 | Second operand |
| psw_we | input | 1 | Write the whole status word |
| psw_wd | input | 8 | Status word write data |
| bit_we | input | 1 | Write one status bit |
| bit_idx | input | 3 | Index of the status bit to write |
| bit_d | input | 1 | Value for the single-bit write |
| cy_set | input | 1 | Force carry to 1 |
| cy_clr | input | 1 | Force carry to 0 |
| acc_q | output | 8 | Accumulator |
| psw_q | output | 8 | Status word, with live parity in bit 0 |

## Verification
The flag properties assume that every control input is a known 0 or 1 at each edge. They apply only to cycles in which no status write command competes with the operation. A cycle that mixes commands is covered only by the priority property for the winning command. The stimulus loads the accumulator and preset flags through a move plus a byte write in one cycle. The operation under test then runs in the next cycle with every status command low. Mixed-command cycles appear only in a handful of directed priority cases, where the expected winner is computed explicitly.

// File: rtl/alu_psw_pkg.sv
package alu_psw_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUBB = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_CPL  = 3'd6,
    OP_MOVE = 3'd7
  } alu_op_e;

  localparam int PSW_W   = 8;
  localparam int BIT_CY  = 7;
  localparam int BIT_AC  = 6;
  localparam int BIT_F0  = 5;
  localparam int BIT_RS1 = 4;
  localparam int BIT_RS0 = 3;
  localparam int BIT_OV  = 2;
  localparam int BIT_NC  = 1;
  localparam int BIT_PAR = 0;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } arith_flags_t;

endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_psw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_op_e       op,
  input  logic          cy_in,
  output logic [DW-1:0] res,
  output arith_flags_t  flg,
  output logic          is_arith
);
  localparam int HALF = DW / 2;

  logic          sub;
  logic          cin;
  logic [DW-1:0] bx;
  logic [DW:0]   full_sum;
  logic [HALF:0] low_sum;
  logic [DW-1:0] upper_in_sum;
  logic          c_out, c_half, c_into_msb;

  always_comb begin
    sub = (op == OP_SUBB);
    unique case (op)
      OP_ADD:  cin = 1'b0;
      OP_ADDC: cin = cy_in;
      OP_SUBB: cin = ~cy_in;
      default: cin = 1'b0;
    endcase
    bx = sub ? ~b : b;
  end

  assign full_sum     = {1'b0, a} + {1'b0, bx} + {{DW{1'b0}}, cin};
  assign low_sum      = {1'b0, a[HALF-1:0]} + {1'b0, bx[HALF-1:0]} + {{HALF{1'b0}}, cin};
  assign upper_in_sum = {1'b0, a[DW-2:0]} + {1'b0, bx[DW-2:0]} + {{(DW-1){1'b0}}, cin};

  assign c_out      = full_sum[DW];
  assign c_half     = low_sum[HALF];
  assign c_into_msb = upper_in_sum[DW-1];

  always_comb begin
    is_arith = (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUBB);
    flg.cy   = sub ? ~c_out  : c_out;
    flg.ac   = sub ? ~c_half : c_half;
    flg.ov   = c_into_msb ^ c_out;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUBB: res = full_sum[DW-1:0];
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_CPL:  res = ~a;
      default: res = b;
    endcase
  end

endmodule

// File: rtl/parity_tree.sv
module parity_tree #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] d,
  output logic          odd
);
  logic [DW-1:0] chain;

  assign chain[0] = d[0];
  for (genvar i = 1; i < DW; i++) begin : g_stage
    assign chain[i] = chain[i-1] ^ d[i];
  end
  assign odd = chain[DW-1];

endmodule

// File: rtl/psw_reg.sv
module psw_reg
  import alu_psw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             arith_upd,
  input  arith_flags_t     flg,
  input  logic             cy_set,
  input  logic             cy_clr,
  input  logic             bit_we,
  input  logic [2:0]       bit_idx,
  input  logic             bit_d,
  input  logic             byte_we,
  input  logic [PSW_W-1:0] byte_d,
  output logic [PSW_W-1:0] stat_q
);
  logic [PSW_W-1:0] nxt;

  always_comb begin
    nxt = stat_q;
    if (arith_upd) begin
      nxt[BIT_CY] = flg.cy;
      nxt[BIT_AC] = flg.ac;
      nxt[BIT_OV] = flg.ov;
    end
    if (cy_clr) nxt[BIT_CY] = 1'b0;
    if (cy_set) nxt[BIT_CY] = 1'b1;
    if (bit_we && (bit_idx > 3'(BIT_NC))) nxt[bit_idx] = bit_d;
    if (byte_we) nxt = byte_d;
    nxt[BIT_NC]  = 1'b0;
    nxt[BIT_PAR] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= nxt;
  end

endmodule

// File: rtl/alu_psw_unit.sv
module alu_psw_unit
  import alu_psw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [2:0]    op_sel,
  input  logic [DW-1:0] opnd_b,
  input  logic          psw_we,
  input  logic [7:0]    psw_wd,
  input  logic          bit_we,
  input  logic [2:0]    bit_idx,
  input  logic          bit_d,
  input  logic          cy_set,
  input  logic          cy_clr,
  output logic [DW-1:0] acc_q,
  output logic [7:0]    psw_q
);
  logic [DW-1:0]    alu_res;
  arith_flags_t     alu_flg;
  logic             alu_arith;
  logic [PSW_W-1:0] stat;
  logic             acc_odd;

  alu_core #(.DW(DW)) u_core (
    .a        (acc_q),
    .b        (opnd_b),
    .op       (alu_op_e'(op_sel)),
    .cy_in    (stat[BIT_CY]),
    .res      (alu_res),
    .flg      (alu_flg),
    .is_arith (alu_arith)
  );

  psw_reg u_psw (
    .clk       (clk),
    .rst       (rst),
    .arith_upd (op_valid && alu_arith),
    .flg       (alu_flg),
    .cy_set    (cy_set),
    .cy_clr    (cy_clr),
    .bit_we    (bit_we),
    .bit_idx   (bit_idx),
    .bit_d     (bit_d),
    .byte_we   (psw_we),
    .byte_d    (psw_wd),
    .stat_q    (stat)
  );

  parity_tree #(.DW(DW)) u_par (
    .d   (acc_q),
    .odd (acc_odd)
  );

  always_ff @(posedge clk) begin
    if (rst)           acc_q <= '0;
    else if (op_valid) acc_q <= alu_res;
  end

  assign psw_q = {stat[PSW_W-1:1], acc_odd};

endmodule

// File: rtl/alu_psw_chk.sv
module alu_psw_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic [2:0]    op_sel,
  input logic [DW-1:0] opnd_b,
  input logic          psw_we,
  input logic [7:0]    psw_wd,
  input logic          bit_we,
  input logic [2:0]    bit_idx,
  input logic          bit_d,
  input logic          cy_set,
  input logic          cy_clr,
  input logic [DW-1:0] acc_q,
  input logic [7:0]    psw_q
);
  logic          quiet;
  logic [DW:0]   add_wide;

  assign quiet    = !psw_we && !bit_we && !cy_set && !cy_clr;
  assign add_wide = {1'b0, acc_q} + {1'b0, opnd_b};

  p_add_carry_r1: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 3'd0 && quiet) |=> (psw_q[7] == $past(add_wide[DW])));

  p_add_sum_r1: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 3'd0) |=> (acc_q == $past(add_wide[DW-1:0])));

  p_logic_keeps_flags_r4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel >= 3'd3 && quiet) |=> $stable(psw_q[7:2]));

  p_parity_live_r5: assert property (@(posedge clk) disable iff (rst)
    psw_q[0] == (($countones(acc_q) % 2) == 1));

  p_set_carry_r6: assert property (@(posedge clk) disable iff (rst)
    (cy_set && !psw_we && !bit_we) |=> psw_q[7]);

  p_clear_carry_r6: assert property (@(posedge clk) disable iff (rst)
    (cy_clr && !cy_set && !psw_we && !bit_we) |=> !psw_q[7]);

  p_byte_write_r7: assert property (@(posedge clk) disable iff (rst)
    psw_we |=> (psw_q[7:2] == $past(psw_wd[7:2]) && !psw_q[1]));

  p_bit_write_r8: assert property (@(posedge clk) disable iff (rst)
    (bit_we && !psw_we && bit_idx == 3'd5) |=> (psw_q[5] == $past(bit_d)));

  p_acc_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(acc_q));

endmodule

bind alu_psw_unit alu_psw_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_alu_psw_unit.sv
module sim_alu_psw_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst;
  logic       op_valid;
  logic [2:0] op_sel;
  logic [7:0] opnd_b;
  logic       psw_we;
  logic [7:0] psw_wd;
  logic       bit_we;
  logic [2:0] bit_idx;
  logic       bit_d;
  logic       cy_set;
  logic       cy_clr;
  logic [7:0] acc_q;
  logic [7:0] psw_q;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;

  alu_psw_unit u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel), .opnd_b(opnd_b),
    .psw_we(psw_we), .psw_wd(psw_wd), .bit_we(bit_we), .bit_idx(bit_idx),
    .bit_d(bit_d), .cy_set(cy_set), .cy_clr(cy_clr), .acc_q(acc_q), .psw_q(psw_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R10 actual=%0d cycles expected=completion", cycles);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic idle();
    op_valid = 0; op_sel = 0; opnd_b = 0; psw_we = 0; psw_wd = 0;
    bit_we = 0; bit_idx = 0; bit_d = 0; cy_set = 0; cy_clr = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] a, input logic [7:0] pv);
    op_valid = 1; op_sel = 3'd7; opnd_b = a; psw_we = 1; psw_wd = pv;
    cyc();
  endtask

  function automatic int sgn(input logic [7:0] v);
    return v[7] ? int'(v) - 256 : int'(v);
  endfunction

  initial begin
    idle();
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    chk("R9 reset acc", acc_q, 8'h00);
    chk("R9 reset psw", psw_q, 8'h00);

    // R1 R2 R3 arithmetic sweep
    for (int op = 0; op < 3; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int bi = 0; bi < 37; bi++) begin
          logic [7:0] av, bv, pv, ea, ep;
          logic cin, cy, ac, ov;
          int s, ss, eff;
          av = 8'(a); bv = 8'(bi * 7);
          cin = av[0] ^ bv[1];
          pv = {cin, 1'b0, av[3:1], 3'b000};
          load(av, pv);
          eff = (op == 0) ? 0 : int'(cin);
          if (op < 2) begin
            s  = a + int'(bv) + eff;
            cy = (s > 255);
            ac = ((a % 16) + int'(bv[3:0]) + eff) > 15;
            ss = sgn(av) + sgn(bv) + eff;
          end else begin
            s  = a - int'(bv) - eff;
            cy = (s < 0);
            ac = (a % 16) < (int'(bv[3:0]) + eff);
            ss = sgn(av) - sgn(bv) - eff;
          end
          ov = (ss > 127) || (ss < -128);
          ea = 8'(s & 255);
          ep = {cy, ac, av[3:1], ov, 1'b0, ^ea};
          op_valid = 1; op_sel = 3'(op); opnd_b = bv;
          cyc();
          if (op == 0) begin
            chk("R1 add acc", acc_q, ea);
            chk("R1 add psw", psw_q, ep);
          end else if (op == 1) begin
            chk("R2 addc acc", acc_q, ea);
            chk("R2 addc psw", psw_q, ep);
          end else begin
            chk("R3 subb acc", acc_q, ea);
            chk("R3 subb psw", psw_q, ep);
          end
        end
      end
    end

    // R4 R5 R7 logic sweep with preset flags
    for (int op = 3; op < 8; op++) begin
      for (int a = 0; a < 256; a += 3) begin
        for (int bi = 0; bi < 24; bi++) begin
          logic [7:0] av, bv, pv, ea;
          av = 8'(a); bv = 8'(bi * 11);
          pv = {av[7:2], 2'b11};
          load(av, pv);
          chk("R5 R7 load psw", psw_q, {av[7:2], 1'b0, ^av});
          case (op)
            3: ea = av & bv;
            4: ea = av | bv;
            5: ea = av ^ bv;
            6: ea = ~av;
            default: ea = bv;
          endcase
          op_valid = 1; op_sel = 3'(op); opnd_b = bv;
          cyc();
          chk("R4 logic acc", acc_q, ea);
          chk("R4 R5 logic psw", psw_q, {av[7:2], 1'b0, ^ea});
        end
      end
    end

    // R8 single-bit writes
    begin
      logic [7:0] em;
      load(8'h00, 8'h00);
      em = 8'h00;
      for (int i = 0; i < 8; i++) begin
        bit_we = 1; bit_idx = 3'(i); bit_d = 1;
        cyc();
        if (i >= 2) em[i] = 1'b1;
        chk("R8 bit set", psw_q, em);
      end
      for (int i = 0; i < 8; i++) begin
        bit_we = 1; bit_idx = 3'(i); bit_d = 0;
        cyc();
        if (i >= 2) em[i] = 1'b0;
        chk("R8 bit clear", psw_q, em);
      end
    end

    // R6 set/clear carry
    load(8'h00, 8'h7C);
    cy_set = 1; cyc();
    chk("R6 set carry", psw_q, 8'hFC);
    cy_clr = 1; cyc();
    chk("R6 clear carry", psw_q, 8'h7C);
    cy_set = 1; cy_clr = 1; cyc();
    chk("R6 set wins", psw_q, 8'hFC);

    // R10 priority and hold
    load(8'hFF, 8'h00);
    op_valid = 1; op_sel = 3'd0; opnd_b = 8'h01; cy_clr = 1;
    cyc();
    chk("R10 clr over add acc", acc_q, 8'h00);
    chk("R10 clr over add psw", psw_q, 8'h40);
    load(8'h00, 8'h00);
    bit_we = 1; bit_idx = 3'd7; bit_d = 0; cy_set = 1;
    cyc();
    chk("R10 bit over set", psw_q, 8'h00);
    load(8'h01, 8'h00);
    psw_we = 1; psw_wd = 8'h18; bit_we = 1; bit_idx = 3'd5; bit_d = 1;
    op_valid = 1; op_sel = 3'd0; opnd_b = 8'h01;
    cyc();
    chk("R10 byte over bit acc", acc_q, 8'h02);
    chk("R10 byte over bit psw", psw_q, 8'h19);
    load(8'h5A, 8'h00);
    op_valid = 0; op_sel = 3'd7; opnd_b = 8'hFF;
    cyc();
    chk("R10 acc hold", acc_q, 8'h5A);

    // R9 mid-run reset
    load(8'hC3, 8'hFC);
    rst = 1; cyc(); rst = 0;
    chk("R9 rerun reset acc", acc_q, 8'h00);
    chk("R9 rerun reset psw", psw_q, 8'h00);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule